// File: doc/BRIEF.md
# Three-Bus Fetch Datapath

This block is a slice of a processor datapath organised around three internal buses. Two source buses (`bus1`, `bus2`) feed a two-input ALU, and the ALU output is the only result bus (`bus3`). Every register in the slice is loaded from the result bus alone. Every move between registers therefore takes one cycle: a source drives one of the two source buses, the ALU passes it through or adds, and the destination captures the result bus.

A small sequencer repeats a three-slot instruction fetch. In the first slot the program counter is copied into the memory address register and a read is strobed. In the second slot the program counter is incremented through the adder, using a constant one placed on `bus2`. In the third slot the fetched word is moved from the memory buffer into the instruction register. External memory is modelled as a combinational word presented on `mem_rdata`. The buffer captures that word in the cycle after the read strobe.

A `halt` input parks the sequencer in an idle slot after a fetch completes. While parked, the low immediate field of the instruction register can be driven onto `bus1`. It is either zero-filled or sign-extended, so its value appears on the result bus without loading any register.

Top module: `tribus_fetch`

## Requirements
- R1: While `rst_n` is low, `pc`, `mar` and `ir` read zero and `slot` reads 0, and this takes effect without waiting for a clock edge. After release, the first fetch starts in slot 0 with `pc` at zero.
- R2: The slot codes are: 0 for the address slot, 1 for the increment slot, 2 for the transfer slot and 3 for idle. The sequence is 0→1→2. From slot 2 or slot 3, the next slot is 3 when `halt` is high and 0 when it is low. `halt` has no effect in slots 0 and 1.
- R3: In slot 0, `bus1` equals `pc` and `bus3` equals `bus1`. `mem_rd` is high in slot 0 and in no other slot. `mar` takes the value of `bus3` at the end of slot 0.
- R4: In slot 1, `bus2` is 1, `bus1` is `pc`, and `bus3` is their sum modulo 2^DATA_W. `pc` takes that sum at the end of slot 1.
- R5: The memory buffer captures `mem_rdata` (addressed by `mar`) at the end of slot 1. In slot 2, `bus2` carries that word, `bus3` equals `bus2`, and `ir` takes `bus3` at the end of slot 2.
- R6: A bus with no enabled source reads zero: `bus2` in slots 0 and 3, `bus1` in slot 2, and `bus1` in slot 3 while `imm_rd` is low, whatever `imm_sext` is.
- R7: In slot 3 with `imm_rd` high and `imm_sext` low, `bus1` carries `ir[IMM_W-1:0]` with the upper bits zero, and `bus3` equals `bus1`. `pc`, `mar` and `ir` do not change in slot 3.
- R8: In slot 3 with both `imm_rd` and `imm_sext` high, bits DATA_W-1..IMM_W of `bus1` are copies of `ir[IMM_W-1]`.
- R9: No bus ever has more than one enabled source in a cycle. `bus1` in slot 1 is exactly `pc`, not a merge of sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt | input | 1 | Park in idle after a fetch completes |
| imm_rd | input | 1 | In idle, drive the IR immediate field onto bus1 |
| imm_sext | input | 1 | Sign-extend the immediate field when it is driven |
| mem_rdata | input | DATA_W | Memory word at address `mar` |
| mem_rd | output | 1 | Memory read strobe |
| slot | output | 2 | Current sequencer slot code |
| pc | output | DATA_W | Program counter |
| mar | output | DATA_W | Memory address register |
| ir | output | DATA_W | Instruction register |
| bus1 | output | DATA_W | First ALU source bus |
| bus2 | output | DATA_W | Second ALU source bus |
| bus3 | output | DATA_W | ALU result bus |

## Verification
The bench builds the block with DATA_W = 32 and IMM_W = 20. With these values, the extension field spans twelve bits above a twenty-bit immediate. The modelled memory makes bit 19 of the fetched word follow the low address bit, so consecutive fetches give the idle slot both a negative and a positive immediate, with non-zero upper bits that zero-filling must clear. The stimulus raises `halt` in slots where it must be ignored, as well as in slots where it parks the sequencer. An asynchronous reset pulled mid-run shows that the registers clear before the next edge.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_INCR = 2'd1,
    SLOT_XFER = 2'd2,
    SLOT_IDLE = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    ALU_PASS_A = 2'd0,
    ALU_PASS_B = 2'd1,
    ALU_SUM    = 2'd2,
    ALU_OFF    = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic    pc_to_a;
    logic    imm_to_a;
    logic    one_to_b;
    logic    buf_to_b;
    logic    imm_signed;
    alu_op_e op;
    logic    ld_mar;
    logic    ld_pc;
    logic    ld_ir;
    logic    rd_strobe;
  } ctl_s;

endpackage

// File: rtl/tbf_seq.sv
module tbf_seq
  import tbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt,
  input  logic  imm_rd,
  input  logic  imm_sext,
  output slot_e slot,
  output ctl_s  ctl
);

  slot_e slot_q;
  slot_e slot_d;

  // next-slot selection
  always_comb begin
    slot_d = slot_q;
    case (slot_q)
      SLOT_ADDR: slot_d = SLOT_INCR;
      SLOT_INCR: slot_d = SLOT_XFER;
      SLOT_XFER: slot_d = halt ? SLOT_IDLE : SLOT_ADDR;
      SLOT_IDLE: slot_d = halt ? SLOT_IDLE : SLOT_ADDR;
      default:   slot_d = SLOT_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_ADDR;
    else        slot_q <= slot_d;
  end

  // strobe decode per slot
  always_comb begin
    ctl = '0;
    ctl.op = ALU_OFF;
    case (slot_q)
      SLOT_ADDR: begin
        ctl.pc_to_a   = 1'b1;
        ctl.op        = ALU_PASS_A;
        ctl.ld_mar    = 1'b1;
        ctl.rd_strobe = 1'b1;
      end
      SLOT_INCR: begin
        ctl.pc_to_a  = 1'b1;
        ctl.one_to_b = 1'b1;
        ctl.op       = ALU_SUM;
        ctl.ld_pc    = 1'b1;
      end
      SLOT_XFER: begin
        ctl.buf_to_b = 1'b1;
        ctl.op       = ALU_PASS_B;
        ctl.ld_ir    = 1'b1;
      end
      default: begin
        ctl.imm_to_a   = imm_rd;
        ctl.imm_signed = imm_sext;
        ctl.op         = ALU_PASS_A;
      end
    endcase
  end

  assign slot = slot_q;

endmodule

// File: rtl/tbf_bus.sv
module tbf_bus
  import tbf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input  ctl_s              ctl,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] mbr,
  input  logic [IMM_W-1:0]  ir_lo,
  output logic [DATA_W-1:0] bus_a,
  output logic [DATA_W-1:0] bus_b,
  output logic [1:0]        en_a,
  output logic [1:0]        en_b
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int NSRC  = 2;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [EXT_W-1:0]  ext_bits;
  logic [DATA_W-1:0] imm_word;
  logic [DATA_W-1:0] src_a [NSRC];
  logic [DATA_W-1:0] src_b [NSRC];
  logic [DATA_W-1:0] term_a [NSRC];
  logic [DATA_W-1:0] term_b [NSRC];

  assign ext_bits = ctl.imm_signed ? {EXT_W{ir_lo[IMM_W-1]}} : '0;
  assign imm_word = {ext_bits, ir_lo};

  assign src_a[0] = pc;
  assign src_a[1] = imm_word;
  assign src_b[0] = ONE;
  assign src_b[1] = mbr;
  assign en_a     = {ctl.imm_to_a, ctl.pc_to_a};
  assign en_b     = {ctl.buf_to_b, ctl.one_to_b};

  // gated sources, one per enable
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign term_a[g] = {DATA_W{en_a[g]}} & src_a[g];
    assign term_b[g] = {DATA_W{en_b[g]}} & src_b[g];
  end

  always_comb begin
    bus_a = '0;
    bus_b = '0;
    for (int i = 0; i < NSRC; i++) begin
      bus_a = bus_a | term_a[i];
      bus_b = bus_b | term_b[i];
    end
  end

endmodule

// File: rtl/tbf_alu.sv
module tbf_alu
  import tbf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      ALU_PASS_A: y = a;
      ALU_PASS_B: y = b;
      ALU_SUM:    y = a + b;
      default:    y = '0;
    endcase
  end

endmodule

// File: rtl/tribus_fetch.sv
module tribus_fetch
  import tbf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              imm_rd,
  input  logic              imm_sext,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [1:0]        slot,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] mar,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] bus1,
  output logic [DATA_W-1:0] bus2,
  output logic [DATA_W-1:0] bus3
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;
  slot_e             slot_s;
  ctl_s              ctl;
  logic [1:0]        en_a;
  logic [1:0]        en_b;
  logic [DATA_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic [DATA_W-1:0] mbr_q, mbr_d;
  logic              rd_pend_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  tbf_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .halt     (halt),
    .imm_rd   (imm_rd),
    .imm_sext (imm_sext),
    .slot     (slot_s),
    .ctl      (ctl)
  );

  tbf_bus #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bus (
    .ctl   (ctl),
    .pc    (pc_q),
    .mbr   (mbr_q),
    .ir_lo (ir_q[IMM_W-1:0]),
    .bus_a (bus1),
    .bus_b (bus2),
    .en_a  (en_a),
    .en_b  (en_b)
  );

  tbf_alu #(.DATA_W(DATA_W)) u_alu (
    .op (ctl.op),
    .a  (bus1),
    .b  (bus2),
    .y  (bus3)
  );

  // register next values with explicit load enables
  always_comb begin
    pc_d  = ctl.ld_pc  ? bus3      : pc_q;
    mar_d = ctl.ld_mar ? bus3      : mar_q;
    ir_d  = ctl.ld_ir  ? bus3      : ir_q;
    mbr_d = rd_pend_q  ? mem_rdata : mbr_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q      <= '0;
      mar_q     <= '0;
      ir_q      <= '0;
      mbr_q     <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      mar_q     <= mar_d;
      ir_q      <= ir_d;
      mbr_q     <= mbr_d;
      rd_pend_q <= ctl.rd_strobe;
    end
  end

  assign mem_rd = ctl.rd_strobe;
  assign slot   = slot_s;
  assign pc     = pc_q;
  assign mar    = mar_q;
  assign ir     = ir_q;

endmodule

// File: rtl/tbf_chk.sv
module tbf_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt,
  input logic              imm_rd,
  input logic              imm_sext,
  input logic              mem_rd,
  input logic [1:0]        slot,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] mar,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] bus1,
  input logic [DATA_W-1:0] bus2,
  input logic [1:0]        en_a,
  input logic [1:0]        en_b
);

  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd2 && !halt) |=> slot == 2'd0);

  // R2
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot >= 2'd2 && halt) |=> slot == 2'd3);

  // R3
  mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (slot == 2'd1 && mar == $past(bus1)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot == 2'd1 |=> pc == $past(pc) + DATA_W'(1));

  // R5
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot == 2'd2 |=> ir == $past(bus2));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot == 2'd3 |=> ($stable(pc) && $stable(mar) && $stable(ir)));

  // R8
  sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd3 && imm_rd && imm_sext) |->
      bus1[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){ir[IMM_W-1]}});

  // R9
  one_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_a));

  // R9
  one_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_b));

  // R6
  idle_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot == 2'd3 |-> bus2 == '0);

endmodule

bind tribus_fetch tbf_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .halt     (halt),
  .imm_rd   (imm_rd),
  .imm_sext (imm_sext),
  .mem_rd   (mem_rd),
  .slot     (slot),
  .pc       (pc),
  .mar      (mar),
  .ir       (ir),
  .bus1     (bus1),
  .bus2     (bus2),
  .en_a     (en_a),
  .en_b     (en_b)
);

// File: tb/sim_tribus_fetch.sv
module sim_tribus_fetch;

  localparam int DW = 32;
  localparam int IW = 20;
  localparam int NROWS = 19;

  // row: {halt, imm_rd, imm_sext, expected slot}
  localparam logic [4:0] ROWS [NROWS] = '{
    {3'b000, 2'd0}, {3'b100, 2'd1}, {3'b000, 2'd2},
    {3'b100, 2'd0}, {3'b000, 2'd1}, {3'b100, 2'd2},
    {3'b110, 2'd3}, {3'b111, 2'd3}, {3'b101, 2'd3},
    {3'b011, 2'd3}, {3'b000, 2'd0}, {3'b000, 2'd1},
    {3'b100, 2'd2}, {3'b111, 2'd3}, {3'b010, 2'd3},
    {3'b000, 2'd0}, {3'b000, 2'd1}, {3'b000, 2'd2},
    {3'b000, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n, halt, imm_rd, imm_sext;
  logic [DW-1:0] mem_rdata;
  logic          mem_rd;
  logic [1:0]    slot;
  logic [DW-1:0] pc, mar, ir, bus1, bus2, bus3;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [DW-1:0] a);
    return {12'hABC, a[0], 7'h15, a[11:0]};
  endfunction

  assign mem_rdata = mem_word(mar);

  tribus_fetch #(.DATA_W(DW), .IMM_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt), .imm_rd(imm_rd),
    .imm_sext(imm_sext), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .slot(slot), .pc(pc), .mar(mar), .ir(ir),
    .bus1(bus1), .bus2(bus2), .bus3(bus3)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  // model state
  logic [1:0]    m_slot;
  logic [DW-1:0] m_pc, m_mar, m_ir, m_mbr;
  logic [DW-1:0] e1, e2, e3;

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_slot = 2'd0; m_pc = '0; m_mar = '0; m_ir = '0; m_mbr = '0;
  endtask

  initial begin
    rst_n = 1'b0; halt = 1'b0; imm_rd = 1'b0; imm_sext = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", pc, '0);
    chk("R1", mar, '0);
    chk("R1", ir, '0);
    chk("R1", {30'd0, slot}, 32'd0);
    release_reset();

    for (int i = 0; i < NROWS; i++) begin
      logic [1:0]    n_slot;
      logic [DW-1:0] n_pc, n_mar, n_ir, n_mbr, imm;
      {halt, imm_rd, imm_sext} = ROWS[i][4:2];
      #1;
      chk("R2", {30'd0, slot}, {30'd0, ROWS[i][1:0]});
      chk("R2", {30'd0, slot}, {30'd0, m_slot});
      chk("R3", {31'd0, mem_rd}, {31'd0, m_slot == 2'd0});
      n_slot = m_slot; n_pc = m_pc; n_mar = m_mar; n_ir = m_ir; n_mbr = m_mbr;
      case (m_slot)
        2'd0: begin
          e1 = m_pc; e2 = '0; e3 = m_pc;
          chk("R3", bus1, e1); chk("R3", bus3, e3); chk("R6", bus2, e2);
          n_mar = e3; n_slot = 2'd1;
        end
        2'd1: begin
          e1 = m_pc; e2 = 32'd1; e3 = m_pc + 32'd1;
          chk("R9", bus1, e1); chk("R4", bus2, e2); chk("R4", bus3, e3);
          n_pc = e3; n_mbr = mem_word(m_mar); n_slot = 2'd2;
        end
        2'd2: begin
          e1 = '0; e2 = m_mbr; e3 = m_mbr;
          chk("R6", bus1, e1); chk("R5", bus2, e2); chk("R5", bus3, e3);
          n_ir = e3; n_slot = halt ? 2'd3 : 2'd0;
        end
        default: begin
          imm = {12'd0, m_ir[IW-1:0]};
          if (imm_sext) imm[DW-1:IW] = {(DW-IW){m_ir[IW-1]}};
          e1 = imm_rd ? imm : '0; e2 = '0; e3 = e1;
          if (!imm_rd)      chk("R6", bus1, e1);
          else if (imm_sext) chk("R8", bus1, e1);
          else              chk("R7", bus1, e1);
          chk("R7", bus3, e3); chk("R6", bus2, e2);
          n_slot = halt ? 2'd3 : 2'd0;
        end
      endcase
      chk("R4", pc, m_pc);
      chk("R3", mar, m_mar);
      chk("R7", ir, m_ir);
      @(posedge clk);
      m_slot = n_slot; m_pc = n_pc; m_mar = n_mar; m_ir = n_ir; m_mbr = n_mbr;
      @(negedge clk);
    end

    // R1 asynchronous reset mid-run, registers clear before next edge
    halt = 1'b0; imm_rd = 1'b0; imm_sext = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    chk("R1", pc, '0);
    chk("R1", mar, '0);
    chk("R1", ir, '0);
    chk("R1", {30'd0, slot}, 32'd0);
    release_reset();
    #1;
    chk("R1", {30'd0, slot}, 32'd0);
    chk("R1", bus1, '0);
    chk("R3", {31'd0, mem_rd}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R4", pc, 32'd1);
    chk("R5", bus2, mem_word(32'd0));
    finish_run();
  end

endmodule